// File: doc/BRIEF.md
# FIFO Depth-Expansion Token Controller

This block is the ownership logic inside one slice of a FIFO that can be joined with other slices into a deeper queue. The slices are wired in a ring. Each slice's expansion output feeds the expansion input of the next slice, and the last slice feeds the first. At any moment, exactly one slice in the ring may accept writes and exactly one may accept reads. Both rights travel as tokens. A slice hands its write token onward when an accepted write lands on its last memory location. It hands its read token onward when an accepted read leaves its last location. The hand-off is signalled on the expansion output in that same cycle.

The write and read system strobes go to every slice. Each controller turns them into local accepts only while it holds the matching token. The slice's own pointers tell the controller when they sit at the last location. The memory array and the flag arithmetic stay outside this block.

A mode strap lets the slice run alone. In that mode it stands in for an expansion input that is tied to ground. Both accepts then follow the strobes without any token. The expansion output carries the half-full flag. The retransmit request reaches the read-pointer rewind output.

Top module: `fifo_chain_token_ctl`

## Requirements
- R1: During reset, a slice whose `first_n` strap is low takes both tokens. Every other slice takes neither. Reset drives `x_out` to 00 in ring mode.
- R2: In ring mode, `wr_ok` is high exactly when `wr_req` is high and the slice holds the write token. A write strobe at a slice without the token has no effect.
- R3: In ring mode, `rd_ok` is high exactly when `rd_req` is high and the slice holds the read token. A read strobe at a slice without the token has no effect.
- R4: In ring mode, bit 0 of `x_out` is high in the same cycle that `wr_ok` and `wr_last` are both high. At the next edge the slice gives up the write token.
- R5: In ring mode, bit 1 of `x_out` is high in the same cycle that `rd_ok` and `rd_last` are both high. At the next edge the slice gives up the read token.
- R6: In ring mode, a high bit 0 of `x_in` gives the slice the write token at the next edge. A high bit 1 gives it the read token. With no pass in and no pass out, both tokens hold. A write pass and a read pass may happen in the same cycle at different slices.
- R7: With `solo` high, `wr_ok` equals `wr_req` and `rd_ok` equals `rd_req`. `x_out` is {0, `hf_in`}, and `x_in` is ignored.
- R8: `rd_rewind` follows `rt_req` when `solo` is high. It stays low in ring mode.
- R9: In a ring of three slices, words written past the capacity of one slice come back out in write order across the slice boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| solo | input | 1 | Mode strap: 1 = stand-alone, 0 = ring |
| first_n | input | 1 | Low on the slice that owns both tokens after reset |
| x_in | input | 2 | Pass code from the previous slice: bit 0 = write token, bit 1 = read token |
| x_out | output | 2 | Pass code to the next slice; {0, half-full} when stand-alone |
| wr_req | input | 1 | System write strobe |
| wr_last | input | 1 | The slice's write pointer is at its last location |
| rd_req | input | 1 | System read strobe |
| rd_last | input | 1 | The slice's read pointer is at its last location |
| hf_in | input | 1 | Half-full flag from the slice's flag logic |
| rt_req | input | 1 | Retransmit request |
| wr_ok | output | 1 | Write accepted by this slice this cycle |
| rd_ok | output | 1 | Read accepted by this slice this cycle |
| wr_tok | output | 1 | This slice holds the write token |
| rd_tok | output | 1 | This slice holds the read token |
| rd_rewind | output | 1 | Rewind the read pointer to the first location |

## Verification
The bench joins three slices into a ring. It writes beyond one slice's capacity and later wraps the whole ring. It also reaches a state where one slice passes the write token while another passes the read token in the same cycle. A design that delayed a pass by one cycle would leave a gap in which a strobe hits no owner and a word is lost. A design that kept a token after passing it would make two slices accept the same strobe. Either fault breaks the read order or the one-owner check that runs every cycle. Stand-alone mode is then checked with changing half-full and retransmit inputs. A leak of ring behaviour into that mode shows up as a gated strobe, a pass code on bit 1, or a rewind that goes missing.

// File: rtl/fifo_chain_token_ctl.sv
module fifo_chain_token_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       solo,
  input  logic       first_n,
  input  logic [1:0] x_in,
  output logic [1:0] x_out,
  input  logic       wr_req,
  input  logic       wr_last,
  input  logic       rd_req,
  input  logic       rd_last,
  input  logic       hf_in,
  input  logic       rt_req,
  output logic       wr_ok,
  output logic       rd_ok,
  output logic       wr_tok,
  output logic       rd_tok,
  output logic       rd_rewind
);
  logic wr_pass, rd_pass;

  assign wr_ok     = wr_req & (solo | wr_tok);
  assign rd_ok     = rd_req & (solo | rd_tok);
  assign wr_pass   = ~solo & wr_ok & wr_last;
  assign rd_pass   = ~solo & rd_ok & rd_last;
  assign x_out     = solo ? {1'b0, hf_in} : {rd_pass, wr_pass};
  assign rd_rewind = solo & rt_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_tok <= ~first_n;
      rd_tok <= ~first_n;
    end else if (!solo) begin
      wr_tok <= (wr_tok & ~wr_pass) | x_in[0];
      rd_tok <= (rd_tok & ~rd_pass) | x_in[1];
    end
  end
endmodule

module fifo_chain_token_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       solo,
  input logic [1:0] x_in,
  input logic [1:0] x_out,
  input logic       wr_req,
  input logic       rd_req,
  input logic       rt_req,
  input logic       wr_ok,
  input logic       rd_ok,
  input logic       wr_tok,
  input logic       rd_tok,
  input logic       rd_rewind
);
  a_r4_pass_from_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && x_out[0] |-> wr_tok && wr_req);
  a_r5_pass_from_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && x_out[1] |-> rd_tok && rd_req);
  a_r4_wr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && x_out[0] && !x_in[0] |=> !wr_tok);
  a_r5_rd_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && x_out[1] && !x_in[1] |=> !rd_tok);
  a_r6_wr_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && x_in[0] |=> wr_tok);
  a_r6_rd_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && x_in[1] |=> rd_tok);
  a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && !x_in[0] && !x_out[0] |=> wr_tok == $past(wr_tok));
  a_r2_no_owner_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && !wr_tok |-> !wr_ok);
  a_r7_solo_accept: assert property (@(posedge clk) disable iff (!rst_n)
    solo && (wr_req || rd_req) |-> (wr_ok == wr_req) && (rd_ok == rd_req));
  a_r8_no_rewind_ring: assert property (@(posedge clk) disable iff (!rst_n)
    !solo && rt_req |-> !rd_rewind);
endmodule

bind fifo_chain_token_ctl fifo_chain_token_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .solo(solo), .x_in(x_in), .x_out(x_out),
  .wr_req(wr_req), .rd_req(rd_req), .rt_req(rt_req), .wr_ok(wr_ok),
  .rd_ok(rd_ok), .wr_tok(wr_tok), .rd_tok(rd_tok), .rd_rewind(rd_rewind));

// File: tb/fifo_chain_token_ctl_bench.sv
module fifo_chain_token_ctl_bench;
  localparam int PERIOD = 10;
  localparam int NS     = 3;
  localparam int DEPTH  = 4;

  logic clk = 0, rst_n = 0, solo = 0;
  logic wr_req = 0, rd_req = 0, rt_req = 0, hf_in = 0;
  logic [1:0] xo [NS];
  logic [NS-1:0] wok, rok, wtk, rtk, rrw, wl, rl;
  int wp [NS], rp [NS];
  logic [7:0] mem [NS][DEPTH];
  logic [7:0] q [$];
  logic [7:0] din = 0;
  int mw_own = 0, mr_own = 0, mw_cnt = 0, mr_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    assign wl[i] = (wp[i] == DEPTH-1);
    assign rl[i] = (rp[i] == DEPTH-1);
    fifo_chain_token_ctl u_fifo_chain_token_ctl (
      .clk(clk), .rst_n(rst_n), .solo(solo), .first_n(i != 0),
      .x_in(xo[(i+NS-1)%NS]), .x_out(xo[i]),
      .wr_req(wr_req), .wr_last(wl[i]), .rd_req(rd_req), .rd_last(rl[i]),
      .hf_in(hf_in), .rt_req(rt_req),
      .wr_ok(wok[i]), .rd_ok(rok[i]), .wr_tok(wtk[i]), .rd_tok(rtk[i]),
      .rd_rewind(rrw[i]));
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step(input logic w, input logic r, input logic rt, input logic hf);
    int nwp [NS];
    int nrp [NS];
    @(negedge clk);
    wr_req = w; rd_req = r; rt_req = rt; hf_in = hf; din = din + 8'd1;
    #1;
    for (int i = 0; i < NS; i++) begin
      logic ew, er;
      logic [1:0] ex;
      ew = w && (solo || i == mw_own);
      er = r && (solo || i == mr_own);
      ex = solo ? {1'b0, hf} :
           {er && mr_cnt == DEPTH-1, ew && mw_cnt == DEPTH-1};
      chk(wok[i] == ew, solo ? "R7 wr_ok" : "R2 wr_ok", wok[i], ew);
      chk(rok[i] == er, solo ? "R7 rd_ok" : "R3 rd_ok", rok[i], er);
      chk(xo[i] == ex, solo ? "R7 x_out" : "R4/R5 x_out", xo[i], ex);
      chk(rrw[i] == (solo && rt), "R8 rd_rewind", rrw[i], solo && rt);
      if (!solo) begin
        chk(wtk[i] == (i == mw_own), "R6 wr_tok", wtk[i], i == mw_own);
        chk(rtk[i] == (i == mr_own), "R6 rd_tok", rtk[i], i == mr_own);
      end
    end
    for (int i = 0; i < NS; i++) begin
      nwp[i] = wp[i];
      nrp[i] = rp[i];
    end
    if (!solo) begin
      for (int i = 0; i < NS; i++) begin
        if (rok[i]) begin
          chk(mem[i][rp[i]] == q[0], "R9 read order", mem[i][rp[i]], q[0]);
          nrp[i] = (rp[i] + 1) % DEPTH;
        end
        if (wok[i]) begin
          mem[i][wp[i]] = din;
          nwp[i] = (wp[i] + 1) % DEPTH;
        end
      end
      if (r) begin
        void'(q.pop_front());
        mr_cnt++;
        if (mr_cnt == DEPTH) begin mr_cnt = 0; mr_own = (mr_own + 1) % NS; end
      end
      if (w) begin
        q.push_back(din);
        mw_cnt++;
        if (mw_cnt == DEPTH) begin mw_cnt = 0; mw_own = (mw_own + 1) % NS; end
      end
    end
    @(posedge clk); #1;
    for (int i = 0; i < NS; i++) begin
      wp[i] = nwp[i];
      rp[i] = nrp[i];
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NS; i++) begin wp[i] = 0; rp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NS; i++) begin
      chk(wtk[i] == (i == 0), "R1 reset wr_tok", wtk[i], i == 0);
      chk(rtk[i] == (i == 0), "R1 reset rd_tok", rtk[i], i == 0);
      chk(xo[i] == 2'b00, "R1 reset x_out", xo[i], 0);
    end
    rst_n = 1;
    step(0, 0, 1, 1);
    // fill past one slice, then rewind-free reads
    for (int k = 0; k < 7; k++) step(1, 0, 0, k[0]);
    for (int k = 0; k < 3; k++) step(0, 1, 1, 0);
    // write pass at slice 1 and read pass at slice 0 in one cycle (R6)
    step(1, 1, 0, 0);
    for (int k = 0; k < 80; k++) begin
      logic w, r;
      w = $urandom_range(0, 1) && (q.size() < NS*DEPTH);
      r = $urandom_range(0, 1) && (q.size() > 0);
      step(w, r, $urandom_range(0, 1), $urandom_range(0, 1));
    end
    while (q.size() > 0) step(0, 1, 0, 0);
    chk(mr_own == mw_own && mr_cnt == mw_cnt, "R9 drained", mr_own, mw_own);

    // stand-alone mode
    @(negedge clk);
    rst_n = 0; solo = 1; wr_req = 0; rd_req = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    step(1, 0, 0, 1);
    step(0, 1, 1, 0);
    step(1, 1, 1, 1);
    step(0, 0, 0, 1);
    step(1, 1, 0, 0);
    finish_run();
  end
endmodule